// File: doc/BRIEF.md
# Three-Channel Interval Timer with Watchdog Reset

This block is a bus-attached peripheral holding three independent up-counting timers. Each timer divides the clock by a 16-bit prescaler, counts up from zero toward a 16-bit limit, and raises a sticky interrupt flag when it gets there. A periodic timer then wraps back to zero and keeps going. A one-shot timer parks at its limit until software restarts it. One shared global register restarts timers and clears their interrupts. Writing a one to a bit acts on it, writing a zero leaves it alone, and a read returns only the pending flags.

Timer 1 can also serve as a watchdog. A reset-status register holds two arm bits, one for the system reset output and one for the external reset output. If timer 1 reaches its limit while either arm bit is set, the selected outputs pulse for a fixed number of cycles and a sticky watchdog-cause flag is set. Software keeps the watchdog quiet by restarting timer 1 before it expires. The same register also holds a software-reset cause flag. Writing a one to that flag requests a system reset pulse.

Registers use a single-cycle 32-bit bus. A write is taken on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Top module: `tri_timer_wdog`

## Requirements
- R1: After reset, all registers read zero: every control, limit and count register, the global register and the reset-status register. `irq`, `sys_rst_o` and `ext_rst_o` are low.
- R2: Each timer sits at a base address of 0x10 for timer 0, 0x20 for timer 1 and 0x30 for timer 2. The control register is at base+0x0. Its bits 31:16 hold the prescaler, bit 7 the enable and bit 4 auto-reload, and other bits read zero. The limit is at base+0x4 in bits 15:0. The count is at base+0x8 and is read-only. Control and limit read back as written.
- R3: An enabled timer with prescaler P adds one to its count every P clock cycles. The first increment falls P cycles after the edge that writes the enable. A prescaler of 0 acts as 1.
- R4: On the increment that brings the count to the limit, the timer sets its interrupt flag. With auto-reload clear (one-shot), the count then holds at the limit and stops.
- R5: With auto-reload set (periodic), the increment that reaches the limit loads the count with zero and sets the flag, and counting continues.
- R6: The global register is at 0x00. Writing a one to bit n (n=0..2) clears timer n's flag. Writing a one to bit 8+n clears timer n's count and prescaler phase and re-arms a stopped one-shot timer. Zero bits have no effect. A read returns the flags in bits 2:0 and zero elsewhere.
- R7: `irq[n]` is high exactly while timer n's flag is set.
- R8: The reset-status register is at 0x40. Bit 31 arms the system reset output and bit 30 arms the external reset output. When timer 1 reaches its limit with either arm bit set, each armed output goes high for 4 cycles from the next cycle, and cause flag bit 1 is set.
- R9: Cause bit 1 stays set until a write to 0x40 has bit 1 at zero. Writing a one to bit 1 never sets it.
- R10: Restarting timer 1 through the global register before it reaches its limit prevents any reset pulse and leaves bit 1 clear.
- R11: With bits 31 and 30 both clear, timer 1 reaching its limit only sets its interrupt flag. Neither reset output pulses.
- R12: Writing 0x40 with bit 2 set pulses `sys_rst_o` alone for 4 cycles and sets cause bit 2. A write with bit 2 at zero clears bit 2.
- R13: Clearing the enable freezes both the count and the prescaler phase. Setting it again resumes counting from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 3 | Per-timer interrupt flags |
| sys_rst_o | output | 1 | System reset request pulse |
| ext_rst_o | output | 1 | External reset output pulse |

## Verification
The bench checks the exact cycle of each increment and of the limit hit. A prescaler off by one, or a compare against limit minus one, would move the count or the flag by a cycle. It pauses a timer in the middle of a prescaler period and then re-enables it. A design that cleared its divider on disable would then step late. It writes zeros and sets restart and acknowledge together in one write, which catches a register that stores the write data or gives one action priority over the other. For the watchdog it checks that steady restarts keep both outputs low. It also checks the pulse width, which output follows which arm bit, that a written one cannot set the cause flag, and that a software reset leaves the external output untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Global register field positions
  localparam int unsigned ACK_LSB     = 0;
  localparam int unsigned RESTART_LSB = 8;

  // Control register field positions
  localparam int unsigned PRES_LSB = 16;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned AL_BIT   = 4;

  // Reset-status register field positions
  localparam int unsigned SYS_ARM_BIT = 31;
  localparam int unsigned EXT_ARM_BIT = 30;
  localparam int unsigned SW_FLAG_BIT = 2;
  localparam int unsigned WD_FLAG_BIT = 1;

  localparam logic [7:0] GLB_ADDR = 8'h00;

  typedef enum logic [1:0] {
    SUB_CTL  = 2'd0,
    SUB_LIM  = 2'd1,
    SUB_CNT  = 2'd2,
    SUB_NONE = 2'd3
  } sub_reg_e;

  function automatic sub_reg_e decode_sub(input logic [3:0] off);
    case (off)
      4'h0:    return SUB_CTL;
      4'h4:    return SUB_LIM;
      4'h8:    return SUB_CNT;
      default: return SUB_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [PW-1:0] ctl_pres,
  input  logic          ctl_en,
  input  logic          ctl_al,
  input  logic          lim_we,
  input  logic [CW-1:0] lim_val,
  input  logic          restart,
  input  logic          ack,
  output logic [PW-1:0] pres_q,
  output logic          en_q,
  output logic          al_q,
  output logic [CW-1:0] lim_q,
  output logic [CW-1:0] cnt_q,
  output logic          flag_q,
  output logic          hit
);

  logic [PW-1:0] pres_n, div_q, div_n, pres_m1;
  logic          en_n, al_n, done_q, done_n, flag_n, running, tick;
  logic [CW-1:0] lim_n, cnt_n;
  logic [CW:0]   cnt_inc;

  always_comb begin
    pres_n = pres_q;
    en_n   = en_q;
    al_n   = al_q;
    if (ctl_we) begin
      pres_n = ctl_pres;
      en_n   = ctl_en;
      al_n   = ctl_al;
    end
    lim_n = lim_we ? lim_val : lim_q;

    pres_m1 = (pres_q == '0) ? '0 : pres_q - 1'b1;
    running = en_q && !done_q;
    tick    = running && (div_q == pres_m1);
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit     = tick && (cnt_inc >= {1'b0, lim_q});

    cnt_n  = cnt_q;
    div_n  = div_q;
    done_n = done_q;
    if (restart) begin
      cnt_n  = '0;
      div_n  = '0;
      done_n = 1'b0;
    end else if (running) begin
      div_n = tick ? '0 : div_q + 1'b1;
      if (hit) begin
        cnt_n  = al_q ? '0 : lim_q;
        done_n = !al_q;
      end else if (tick) begin
        cnt_n = cnt_inc[CW-1:0];
      end
    end

    if (hit)      flag_n = 1'b1;
    else if (ack) flag_n = 1'b0;
    else          flag_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      en_q   <= 1'b0;
      al_q   <= 1'b0;
      lim_q  <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pres_q <= pres_n;
      en_q   <= en_n;
      al_q   <= al_n;
      lim_q  <= lim_n;
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      done_q <= done_n;
      flag_q <= flag_n;
    end
  end

endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_sys,
  input  logic fire_ext,
  output logic sys_o,
  output logic ext_o
);

  localparam int unsigned LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LEN_V = LW'(LEN);

  logic [LW-1:0] left_q, left_n;
  logic          sel_sys_q, sel_sys_n, sel_ext_q, sel_ext_n, active;

  always_comb begin
    active    = (left_q != '0);
    left_n    = left_q;
    sel_sys_n = sel_sys_q;
    sel_ext_n = sel_ext_q;
    if (fire_sys || fire_ext) begin
      left_n    = LEN_V;
      sel_sys_n = fire_sys || (active && sel_sys_q);
      sel_ext_n = fire_ext || (active && sel_ext_q);
    end else if (active) begin
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      sel_sys_q <= 1'b0;
      sel_ext_q <= 1'b0;
    end else begin
      left_q    <= left_n;
      sel_sys_q <= sel_sys_n;
      sel_ext_q <= sel_ext_n;
    end
  end

  assign sys_o = active && sel_sys_q;
  assign ext_o = active && sel_ext_q;

endmodule

// File: rtl/tri_timer_wdog.sv
module tri_timer_wdog
  import tmr_pkg::*;
#(
  parameter int unsigned NCH       = 3,
  parameter int unsigned PW        = 16,
  parameter int unsigned CW        = 16,
  parameter int unsigned WD_CH     = 1,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     bus_addr,
  input  logic           bus_we,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq,
  output logic           sys_rst_o,
  output logic           ext_rst_o
);

  localparam logic [7:0] RSTAT_ADDR = 8'((NCH + 1) * 16);

  logic [PW-1:0]  ch_pres [NCH];
  logic [CW-1:0]  ch_lim  [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] ch_en, ch_al, ch_flag, ch_hit;
  logic [NCH-1:0] ch_ctl_we, ch_lim_we, ch_restart, ch_ack;
  logic           glb_we, rstat_we, sw_req, wd_fire;
  logic           sys_arm_q, sys_arm_n, ext_arm_q, ext_arm_n;
  logic           wd_flag_q, wd_flag_n, sw_flag_q, sw_flag_n;
  sub_reg_e       rd_sub;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign glb_we   = bus_we && (bus_addr == GLB_ADDR);
  assign rstat_we = bus_we && (bus_addr == RSTAT_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic page_hit;
    assign page_hit      = (bus_addr[7:4] == 4'(i + 1));
    assign ch_ctl_we[i]  = bus_we && page_hit && (decode_sub(bus_addr[3:0]) == SUB_CTL);
    assign ch_lim_we[i]  = bus_we && page_hit && (decode_sub(bus_addr[3:0]) == SUB_LIM);
    assign ch_restart[i] = glb_we && bus_wdata[RESTART_LSB + i];
    assign ch_ack[i]     = glb_we && bus_wdata[ACK_LSB + i];

    tmr_channel #(.PW(PW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ch_ctl_we[i]),
      .ctl_pres (bus_wdata[PRES_LSB +: PW]),
      .ctl_en   (bus_wdata[EN_BIT]),
      .ctl_al   (bus_wdata[AL_BIT]),
      .lim_we   (ch_lim_we[i]),
      .lim_val  (bus_wdata[CW-1:0]),
      .restart  (ch_restart[i]),
      .ack      (ch_ack[i]),
      .pres_q   (ch_pres[i]),
      .en_q     (ch_en[i]),
      .al_q     (ch_al[i]),
      .lim_q    (ch_lim[i]),
      .cnt_q    (ch_cnt[i]),
      .flag_q   (ch_flag[i]),
      .hit      (ch_hit[i])
    );
  end

  assign irq = ch_flag;

  // Watchdog arming and reset-cause flags
  assign wd_fire = ch_hit[WD_CH] && (sys_arm_q || ext_arm_q);
  assign sw_req  = rstat_we && bus_wdata[SW_FLAG_BIT];

  always_comb begin
    sys_arm_n = sys_arm_q;
    ext_arm_n = ext_arm_q;
    sw_flag_n = sw_flag_q;
    wd_flag_n = wd_flag_q;
    if (rstat_we) begin
      sys_arm_n = bus_wdata[SYS_ARM_BIT];
      ext_arm_n = bus_wdata[EXT_ARM_BIT];
      sw_flag_n = bus_wdata[SW_FLAG_BIT];
      wd_flag_n = wd_flag_q && bus_wdata[WD_FLAG_BIT];
    end
    if (wd_fire) wd_flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_arm_q <= 1'b0;
      ext_arm_q <= 1'b0;
      sw_flag_q <= 1'b0;
      wd_flag_q <= 1'b0;
    end else begin
      sys_arm_q <= sys_arm_n;
      ext_arm_q <= ext_arm_n;
      sw_flag_q <= sw_flag_n;
      wd_flag_q <= wd_flag_n;
    end
  end

  tmr_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_sys ((wd_fire && sys_arm_q) || sw_req),
    .fire_ext (wd_fire && ext_arm_q),
    .sys_o    (sys_rst_o),
    .ext_o    (ext_rst_o)
  );

  // Read path
  assign rd_sub = decode_sub(bus_addr[3:0]);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == GLB_ADDR) begin
      bus_rdata[ACK_LSB +: NCH] = ch_flag;
    end else if (bus_addr == RSTAT_ADDR) begin
      bus_rdata[SYS_ARM_BIT] = sys_arm_q;
      bus_rdata[EXT_ARM_BIT] = ext_arm_q;
      bus_rdata[SW_FLAG_BIT] = sw_flag_q;
      bus_rdata[WD_FLAG_BIT] = wd_flag_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr[7:4] == 4'(i + 1)) begin
          case (rd_sub)
            SUB_CTL: begin
              bus_rdata[PRES_LSB +: PW] = ch_pres[i];
              bus_rdata[EN_BIT]         = ch_en[i];
              bus_rdata[AL_BIT]         = ch_al[i];
            end
            SUB_LIM: bus_rdata[CW-1:0] = ch_lim[i];
            SUB_CNT: bus_rdata[CW-1:0] = ch_cnt[i];
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tri_timer_wdog_chk.sv
module tri_timer_wdog_chk #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     bus_addr,
  input logic           bus_we,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] irq,
  input logic           sys_rst_o,
  input logic           ext_rst_o,
  input logic [CW-1:0]  cnt0,
  input logic           hit0,
  input logic           hit_wd,
  input logic           sys_arm,
  input logic           wd_flag
);

  localparam logic [7:0] RSTAT_ADDR = 8'((NCH + 1) * 16);

  // R6: acknowledging timer 0 clears its flag unless it hits in that cycle
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h00 && bus_wdata[0] && !hit0) |=> !irq[0]);

  // R6: restarting timer 0 zeroes its count
  a_r6_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h00 && bus_wdata[8]) |=> (cnt0 == '0));

  // R7: a flag rises only from a limit hit
  a_r7_irq_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(hit0));

  // R8, R12: system reset starts only from an armed expiry or a software request
  a_r8_sys_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(hit_wd && sys_arm) ||
      $past(bus_we && bus_addr == RSTAT_ADDR && bus_wdata[2]));

  // R8: pulses last longer than one cycle
  a_r8_ext_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rst_o) |=> ext_rst_o);

  // R9: the watchdog cause flag falls only on a write with bit 1 clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> $past(bus_we && bus_addr == RSTAT_ADDR && !bus_wdata[1]));

endmodule

bind tri_timer_wdog tri_timer_wdog_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .sys_rst_o (sys_rst_o),
  .ext_rst_o (ext_rst_o),
  .cnt0      (ch_cnt[0]),
  .hit0      (ch_hit[0]),
  .hit_wd    (ch_hit[WD_CH]),
  .sys_arm   (sys_arm_q),
  .wd_flag   (wd_flag_q)
);

// File: tb/tri_timer_wdog_tb_top.sv
`timescale 1ns/1ps
module tri_timer_wdog_tb_top;

  typedef struct packed {
    logic [1:0]  k;   // 0 write, 1 read-compare, 2 idle cycles
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  r;   // requirement number
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [NV] = '{
    // R1 reset values
    '{2'd1, 8'h00, 32'h0, 4'd1}, '{2'd1, 8'h10, 32'h0, 4'd1},
    '{2'd1, 8'h18, 32'h0, 4'd1}, '{2'd1, 8'h28, 32'h0, 4'd1},
    '{2'd1, 8'h38, 32'h0, 4'd1}, '{2'd1, 8'h40, 32'h0, 4'd1},
    // R2 readback, R3 prescale 2, R4 one-shot limit 3
    '{2'd0, 8'h14, 32'h3, 4'd2}, '{2'd1, 8'h14, 32'h3, 4'd2},
    '{2'd0, 8'h10, 32'h00020080, 4'd2}, '{2'd1, 8'h10, 32'h00020080, 4'd2},
    '{2'd1, 8'h18, 32'h0, 4'd3}, '{2'd2, 8'h00, 32'd2, 4'd3},
    '{2'd1, 8'h18, 32'h1, 4'd3}, '{2'd2, 8'h00, 32'd2, 4'd3},
    '{2'd1, 8'h18, 32'h2, 4'd3}, '{2'd2, 8'h00, 32'd1, 4'd4},
    '{2'd1, 8'h00, 32'h0, 4'd4}, '{2'd2, 8'h00, 32'd1, 4'd4},
    '{2'd1, 8'h18, 32'h3, 4'd4}, '{2'd1, 8'h00, 32'h1, 4'd4},
    '{2'd2, 8'h00, 32'd6, 4'd4}, '{2'd1, 8'h18, 32'h3, 4'd4},
    // R6 zero write ignored, ack, restart
    '{2'd0, 8'h00, 32'h0, 4'd6}, '{2'd1, 8'h00, 32'h1, 4'd6},
    '{2'd0, 8'h00, 32'h1, 4'd6}, '{2'd1, 8'h00, 32'h0, 4'd6},
    '{2'd0, 8'h00, 32'h100, 4'd6}, '{2'd1, 8'h18, 32'h0, 4'd6},
    '{2'd2, 8'h00, 32'd2, 4'd6}, '{2'd1, 8'h18, 32'h1, 4'd6},
    // R13 pause mid-period, resume
    '{2'd0, 8'h10, 32'h00020000, 4'd13}, '{2'd1, 8'h18, 32'h1, 4'd13},
    '{2'd2, 8'h00, 32'd5, 4'd13}, '{2'd1, 8'h18, 32'h1, 4'd13},
    '{2'd0, 8'h10, 32'h00020080, 4'd13}, '{2'd1, 8'h18, 32'h1, 4'd13},
    '{2'd2, 8'h00, 32'd1, 4'd13}, '{2'd1, 8'h18, 32'h2, 4'd13},
    '{2'd0, 8'h10, 32'h0, 4'd13},
    // R5 periodic, prescaler 0, limit 2 on timer 2
    '{2'd0, 8'h34, 32'h2, 4'd5}, '{2'd0, 8'h30, 32'h90, 4'd5},
    '{2'd1, 8'h30, 32'h90, 4'd2}, '{2'd1, 8'h38, 32'h0, 4'd5},
    '{2'd2, 8'h00, 32'd1, 4'd5}, '{2'd1, 8'h38, 32'h1, 4'd5},
    '{2'd2, 8'h00, 32'd1, 4'd5}, '{2'd1, 8'h38, 32'h0, 4'd5},
    '{2'd1, 8'h00, 32'h4, 4'd5}, '{2'd2, 8'h00, 32'd1, 4'd5},
    '{2'd1, 8'h38, 32'h1, 4'd5}, '{2'd2, 8'h00, 32'd1, 4'd5},
    '{2'd1, 8'h38, 32'h0, 4'd5},
    // R6 restart and ack in one write
    '{2'd0, 8'h00, 32'h404, 4'd6}, '{2'd1, 8'h00, 32'h0, 4'd6},
    '{2'd1, 8'h38, 32'h0, 4'd6}, '{2'd0, 8'h30, 32'h0, 4'd6}
  };

  logic        clk, rst_n, bus_we, sys_rst_o, ext_rst_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  irq;
  int          n_chk, n_fail;
  bit          done;

  tri_timer_wdog dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .sys_rst_o (sys_rst_o),
    .ext_rst_o (ext_rst_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input string req, input logic s, input logic e);
    check({req, " sys"}, {31'd0, sys_rst_o}, {31'd0, s});
    check({req, " ext"}, {31'd0, ext_rst_o}, {31'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    pins("R1", 1'b0, 1'b0);
    check("R1 irq", {29'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].k)
        2'd0: bus_wr(VECS[i].a, VECS[i].d);
        2'd1: bus_chk($sformatf("R%0d @%02h", VECS[i].r, VECS[i].a), VECS[i].a, VECS[i].d);
        default: idle(int'(VECS[i].d));
      endcase
    end

    // R11: disarmed, timer 1 expiry is only an interrupt
    bus_wr(8'h24, 32'd2);
    bus_wr(8'h20, 32'h00010080);
    for (int i = 0; i < 5; i++) begin idle(1); pins("R11", 1'b0, 1'b0); end
    bus_chk("R11 glb", 8'h00, 32'h2);
    check("R7 irq", {29'd0, irq}, 32'h2);
    bus_wr(8'h00, 32'h2);

    // R10: steady restarts keep the watchdog quiet
    bus_wr(8'h24, 32'd4);
    bus_wr(8'h40, 32'hC000_0000);
    bus_chk("R8 arm", 8'h40, 32'hC000_0000);
    bus_wr(8'h00, 32'h200);
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 2; j++) begin idle(1); pins("R10", 1'b0, 1'b0); end
      bus_wr(8'h00, 32'h200);
    end
    bus_chk("R10 flag", 8'h40, 32'hC000_0000);

    // R8: expiry pulses both outputs for 4 cycles
    idle(3);
    pins("R8 before", 1'b0, 1'b0);
    idle(1);
    pins("R8 start", 1'b1, 1'b1);
    bus_chk("R8 flag", 8'h40, 32'hC000_0002);
    idle(3);
    pins("R8 width", 1'b1, 1'b1);
    idle(1);
    pins("R8 end", 1'b0, 1'b0);

    // R9: cleared by a zero, not set by a one
    bus_wr(8'h40, 32'h8000_0000);
    bus_chk("R9 clear", 8'h40, 32'h8000_0000);
    bus_wr(8'h40, 32'h8000_0002);
    bus_chk("R9 no set", 8'h40, 32'h8000_0000);

    // R8: external output only
    bus_wr(8'h40, 32'h4000_0000);
    bus_wr(8'h00, 32'h202);
    idle(4);
    pins("R8 ext only", 1'b0, 1'b1);
    bus_chk("R8 ext flag", 8'h40, 32'h4000_0002);
    idle(4);
    pins("R8 ext end", 1'b0, 1'b0);

    // R12: software reset request
    bus_wr(8'h40, 32'h0);
    bus_chk("R9 zero", 8'h40, 32'h0);
    bus_wr(8'h40, 32'h4);
    pins("R12 pulse", 1'b1, 1'b0);
    bus_chk("R12 flag", 8'h40, 32'h4);
    idle(4);
    pins("R12 end", 1'b0, 1'b0);
    bus_wr(8'h40, 32'h0);
    bus_chk("R12 clear", 8'h40, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule